// File: doc/BRIEF.md
# Dual-Channel Compare Timer

This peripheral holds two identical 32-bit counting channels behind a plain single-cycle register port. Channel 0 normally serves as a free-running time base that software reads to measure elapsed time. Channel 1 serves as a one-shot event source. Software stops it, loads a compare value, zeroes the count and starts it. When the count reaches the compare value, a pending flag is raised. That flag, gated by the channel's interrupt enable, drives the channel's interrupt line.

Every channel has three words: a control word, a compare word and the live count. The control word carries the pending flag, the interrupt enable and the run enable. The pending flag is cleared by writing a one to its bit. Writing a zero to that bit leaves the flag as it is. When software writes the count word, the count takes the written value. The counter keeps running past a match and wraps to zero after its all-ones value.

Top module: `cmp_timer`

## Requirements
- R1: After reset every control, compare and count word of both channels reads zero and both interrupt lines are low.
- R2: Channel 0 occupies byte addresses 0x08/0x0C/0x10 and channel 1 occupies 0x14/0x18/0x1C, ordered as control, compare, count. In the control word, bit 0 is pending, bit 1 is interrupt enable and bit 2 is run. The other control bits read zero.
- R3: While run is set, the count rises by one on each clock. While run is clear, the count holds.
- R4: A write to the count word loads the written value on that edge. The load takes priority over the increment.
- R5: On an edge where run is set and the count equals the compare value, the pending flag is set, whatever the state of the interrupt enable. The flag reads as one from the following cycle.
- R6: Writing control with bit 0 set clears the pending flag. Writing control with bit 0 clear leaves the pending flag unchanged, while bits 1 and 2 still update.
- R7: If a match and a clearing control write fall on the same edge, the pending flag ends up set.
- R8: Each interrupt line is high exactly when that channel's pending flag and interrupt enable are both set.
- R9: After a match the count keeps rising, and it wraps from 0xFFFFFFFF to 0.
- R10: Reads of any address outside the six channel words return zero. Writes to those addresses change nothing.
- R11: A compare value anywhere from 0xF up to 0xFFFFFFFF produces exactly one match, at the predicted edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as the address |
| irq | output | 2 | Interrupt per channel, bit n for channel n |

## Verification
The bench targets the edge where a match happens. It checks that pending stays low one cycle before the match and rises in the cycle after it. A design that compared the next count instead of the current one would flag the match a cycle early. The bench places a clearing control write on exactly the match edge; a clear-wins priority would drop that event. It writes control with bit 0 clear while the flag is pending, which catches a design that treats the bit as a plain stored bit. It also runs a count up through 0xFFFFFFFF, which catches a counter that saturates or does not wrap.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int TMR_DW = 32;

    // control word bit positions (software-visible)
    localparam int CTL_PEND = 0;
    localparam int CTL_IEN  = 1;
    localparam int CTL_RUN  = 2;

    // byte offsets of the words inside one channel block
    localparam int OFS_CTL = 0;
    localparam int OFS_CMP = 4;
    localparam int OFS_CNT = 8;

    typedef struct packed {
        logic              pend;
        logic              ien;
        logic              run;
        logic [TMR_DW-1:0] cmp;
        logic [TMR_DW-1:0] cnt;
    } tmr_state_t;
endpackage

// File: rtl/tmr_regdec.sv
module tmr_regdec #(
    parameter int NCH    = 2,
    parameter int AW     = 8,
    parameter int BASE   = 8,
    parameter int STRIDE = 12
) (
    input  logic           sel,
    input  logic           we,
    input  logic [AW-1:0]  addr,
    output logic [NCH-1:0] wr_ctl,
    output logic [NCH-1:0] wr_cmp,
    output logic [NCH-1:0] wr_cnt,
    output logic [NCH-1:0] rs_ctl,
    output logic [NCH-1:0] rs_cmp,
    output logic [NCH-1:0] rs_cnt
);
    import tmr_pkg::*;

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        localparam logic [AW-1:0] ACTL = AW'(BASE + i*STRIDE + OFS_CTL);
        localparam logic [AW-1:0] ACMP = AW'(BASE + i*STRIDE + OFS_CMP);
        localparam logic [AW-1:0] ACNT = AW'(BASE + i*STRIDE + OFS_CNT);
        logic hit_ctl, hit_cmp, hit_cnt;
        assign hit_ctl   = sel && (addr == ACTL);
        assign hit_cmp   = sel && (addr == ACMP);
        assign hit_cnt   = sel && (addr == ACNT);
        assign wr_ctl[i] = hit_ctl && we;
        assign wr_cmp[i] = hit_cmp && we;
        assign wr_cnt[i] = hit_cnt && we;
        assign rs_ctl[i] = hit_ctl && !we;
        assign rs_cmp[i] = hit_cmp && !we;
        assign rs_cnt[i] = hit_cnt && !we;
    end
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctl,
    input  logic              wr_cmp,
    input  logic              wr_cnt,
    input  logic [TMR_DW-1:0] wdata,
    output logic [TMR_DW-1:0] ctl_word,
    output logic [TMR_DW-1:0] cmp,
    output logic [TMR_DW-1:0] cnt,
    output logic              pend,
    output logic              ien,
    output logic              run,
    output logic              irq
);
    tmr_state_t st_d, st_q;
    logic       match;

    always_comb begin
        st_d  = st_q;
        match = st_q.run && (st_q.cnt == st_q.cmp);

        if (wr_ctl) begin
            st_d.ien = wdata[CTL_IEN];
            st_d.run = wdata[CTL_RUN];
            if (wdata[CTL_PEND]) begin
                st_d.pend = 1'b0;
            end
        end
        // a hardware event outranks a software clear in the same cycle
        if (match) begin
            st_d.pend = 1'b1;
        end

        if (wr_cmp) begin
            st_d.cmp = wdata;
        end

        if (wr_cnt) begin
            st_d.cnt = wdata;
        end else if (st_q.run) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        ctl_word           = '0;
        ctl_word[CTL_PEND] = st_q.pend;
        ctl_word[CTL_IEN]  = st_q.ien;
        ctl_word[CTL_RUN]  = st_q.run;
    end

    assign cmp  = st_q.cmp;
    assign cnt  = st_q.cnt;
    assign pend = st_q.pend;
    assign ien  = st_q.ien;
    assign run  = st_q.run;
    assign irq  = st_q.pend && st_q.ien;
endmodule

// File: rtl/cmp_timer.sv
module cmp_timer
    import tmr_pkg::*;
#(
    parameter int NCH    = 2,
    parameter int AW     = 8,
    parameter int BASE   = 8,
    parameter int STRIDE = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [AW-1:0]     bus_addr,
    input  logic [TMR_DW-1:0] bus_wdata,
    output logic [TMR_DW-1:0] bus_rdata,
    output logic [NCH-1:0]    irq
);
    logic [NCH-1:0] wr_ctl, wr_cmp, wr_cnt;
    logic [NCH-1:0] rs_ctl, rs_cmp, rs_cnt;
    logic [NCH-1:0] pend_w, ien_w, run_w;
    logic [NCH-1:0][TMR_DW-1:0] ctl_w, cmp_w, cnt_w;

    tmr_regdec #(
        .NCH(NCH), .AW(AW), .BASE(BASE), .STRIDE(STRIDE)
    ) u_dec (
        .sel    (bus_sel),
        .we     (bus_we),
        .addr   (bus_addr),
        .wr_ctl (wr_ctl),
        .wr_cmp (wr_cmp),
        .wr_cnt (wr_cnt),
        .rs_ctl (rs_ctl),
        .rs_cmp (rs_cmp),
        .rs_cnt (rs_cnt)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        tmr_chan u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_ctl   (wr_ctl[i]),
            .wr_cmp   (wr_cmp[i]),
            .wr_cnt   (wr_cnt[i]),
            .wdata    (bus_wdata),
            .ctl_word (ctl_w[i]),
            .cmp      (cmp_w[i]),
            .cnt      (cnt_w[i]),
            .pend     (pend_w[i]),
            .ien      (ien_w[i]),
            .run      (run_w[i]),
            .irq      (irq[i])
        );
    end

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NCH; i++) begin
            if (rs_ctl[i]) bus_rdata = bus_rdata | ctl_w[i];
            if (rs_cmp[i]) bus_rdata = bus_rdata | cmp_w[i];
            if (rs_cnt[i]) bus_rdata = bus_rdata | cnt_w[i];
        end
    end
endmodule

// File: rtl/tmr_chk.sv
module tmr_chk
    import tmr_pkg::*;
#(
    parameter int NCH    = 2,
    parameter int AW     = 8,
    parameter int BASE   = 8,
    parameter int STRIDE = 12
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      bus_sel,
    input logic                      bus_we,
    input logic [AW-1:0]             bus_addr,
    input logic                      wd_pend,
    input logic [NCH-1:0]            irq,
    input logic [NCH-1:0]            pend,
    input logic [NCH-1:0]            ien,
    input logic [NCH-1:0]            run,
    input logic [NCH-1:0][TMR_DW-1:0] cmp,
    input logic [NCH-1:0][TMR_DW-1:0] cnt
);
    for (genvar i = 0; i < NCH; i++) begin : g_chk
        logic wctl, wcnt;
        assign wctl = bus_sel && bus_we && (bus_addr == AW'(BASE + i*STRIDE + OFS_CTL));
        assign wcnt = bus_sel && bus_we && (bus_addr == AW'(BASE + i*STRIDE + OFS_CNT));

        a_r3_counts_up: assert property (@(posedge clk) disable iff (!rst_n)
            (run[i] && !wcnt) |=> (cnt[i] == $past(cnt[i]) + 1'b1));

        a_r3_holds: assert property (@(posedge clk) disable iff (!rst_n)
            (!run[i] && !wcnt) |=> $stable(cnt[i]));

        a_r5_match_pends: assert property (@(posedge clk) disable iff (!rst_n)
            (run[i] && (cnt[i] == cmp[i])) |=> pend[i]);

        a_r6_zero_keeps: assert property (@(posedge clk) disable iff (!rst_n)
            (pend[i] && wctl && !wd_pend) |=> pend[i]);

        a_r8_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
            irq[i] == (pend[i] && ien[i]));
    end
endmodule

bind cmp_timer tmr_chk #(
    .NCH(NCH), .AW(AW), .BASE(BASE), .STRIDE(STRIDE)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_sel  (bus_sel),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .wd_pend  (bus_wdata[0]),
    .irq      (irq),
    .pend     (pend_w),
    .ien      (ien_w),
    .run      (run_w),
    .cmp      (cmp_w),
    .cnt      (cnt_w)
);

// File: tb/cmp_timer_tb.sv
module cmp_timer_tb;
    localparam logic [7:0] C0_CTL = 8'h08, C0_CMP = 8'h0C, C0_CNT = 8'h10;
    localparam logic [7:0] C1_CTL = 8'h14, C1_CMP = 8'h18, C1_CNT = 8'h1C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    cmp_timer u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    function automatic logic [31:0] ctl_exp(bit pnd, bit ie, bit rn);
        return {29'd0, rn, ie, pnd};
    endfunction

    task automatic check(string req, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // called at a negedge, returns at the negedge after the write edge
    task automatic wr(logic [7:0] a, logic [31:0] d);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    // combinational read, consumes no edge
    task automatic rd(logic [7:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1;
        d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic edges(int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic arm1(logic [31:0] c, logic [31:0] v, logic [31:0] ctl);
        wr(C1_CTL, 32'h1);
        wr(C1_CMP, c);
        wr(C1_CNT, v);
        wr(C1_CTL, ctl);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [7:0] addrs [6];
        void'($urandom(32'd20240611));
        addrs = '{C0_CTL, C0_CMP, C0_CNT, C1_CTL, C1_CMP, C1_CNT};
        edges(3);
        rst_n = 1'b1;
        edges(1);

        // R1 reset state
        foreach (addrs[k]) begin rd(addrs[k], d); check("R1", d, 32'h0); end
        check("R1 irq", {30'd0, irq}, 32'h0);

        // R10 unused addresses
        rd(8'h00, d); check("R10", d, 0);
        rd(8'h04, d); check("R10", d, 0);
        rd(8'h20, d); check("R10", d, 0);
        rd(8'h0B, d); check("R10", d, 0);
        wr(8'h00, 32'hFFFF_FFFF);
        wr(8'h20, 32'hFFFF_FFFF);
        foreach (addrs[k]) begin rd(addrs[k], d); check("R10 write ignored", d, 32'h0); end

        // R2 map and control bits
        wr(C0_CMP, 32'hA5A5_0001); rd(C0_CMP, d); check("R2", d, 32'hA5A5_0001);
        wr(C1_CMP, 32'h5A5A_0002); rd(C1_CMP, d); check("R2", d, 32'h5A5A_0002);
        rd(C0_CMP, d); check("R2 ch0 intact", d, 32'hA5A5_0001);
        wr(C1_CTL, 32'hFFFF_FFFA); rd(C1_CTL, d); check("R2 ctl", d, ctl_exp(0, 1, 0));
        wr(C1_CTL, 32'h0);

        // R3 counting and hold (cmp on ch0 far away)
        wr(C0_CNT, 0);
        wr(C0_CTL, 32'h4);
        rd(C0_CNT, d); check("R3 start", d, 0);
        edges(10);
        rd(C0_CNT, d); check("R3 count", d, 10);
        wr(C0_CTL, 32'h0);
        rd(C0_CNT, d); check("R3 last", d, 11);
        edges(5);
        rd(C0_CNT, d); check("R3 hold", d, 11);

        // R4 reload, stopped and running
        wr(C0_CNT, 32'h1234); rd(C0_CNT, d); check("R4 stopped", d, 32'h1234);
        wr(C0_CTL, 32'h4);
        wr(C0_CNT, 32'd100); rd(C0_CNT, d); check("R4 running", d, 100);
        edges(1); rd(C0_CNT, d); check("R4 continue", d, 101);

        // R5 / R11 smallest compare, R9 continues
        arm1(32'hF, 0, 32'h6);
        edges(15);
        rd(C1_CTL, d); check("R5 before", d, ctl_exp(0, 1, 1));
        check("R8 before", {31'd0, irq[1]}, 0);
        edges(1);
        rd(C1_CTL, d); check("R5 R11 match", d, ctl_exp(1, 1, 1));
        check("R8 irq", {31'd0, irq[1]}, 1);
        rd(C1_CNT, d); check("R9 keeps counting", d, 16);

        // R6 write zero keeps, write one clears
        wr(C1_CTL, 32'h6); rd(C1_CTL, d); check("R6 keep", d, ctl_exp(1, 1, 1));
        wr(C1_CTL, 32'h7); rd(C1_CTL, d); check("R6 clear", d, ctl_exp(0, 1, 1));
        check("R8 cleared", {31'd0, irq[1]}, 0);

        // R8 / R5 pending without enable
        arm1(32'd20, 0, 32'h4);
        edges(21);
        rd(C1_CTL, d); check("R5 no ien", d, ctl_exp(1, 0, 1));
        check("R8 gated", {31'd0, irq[1]}, 0);
        wr(C1_CTL, 32'h6);
        check("R8 enabled", {31'd0, irq[1]}, 1);

        // R7 set beats clear on the same edge
        arm1(32'd30, 0, 32'h6);
        edges(30);
        rd(C1_CTL, d); check("R7 pre", d, ctl_exp(0, 1, 1));
        wr(C1_CTL, 32'h7);
        rd(C1_CTL, d); check("R7 set wins", d, ctl_exp(1, 1, 1));

        // R9 / R11 wrap with the largest compare
        arm1(32'hFFFF_FFFF, 32'hFFFF_FFF0, 32'h6);
        edges(15);
        rd(C1_CNT, d); check("R9 top", d, 32'hFFFF_FFFF);
        rd(C1_CTL, d); check("R11 before", d, ctl_exp(0, 1, 1));
        edges(1);
        rd(C1_CNT, d); check("R9 wrap", d, 0);
        rd(C1_CTL, d); check("R11 max match", d, ctl_exp(1, 1, 1));

        // random compare values and register data
        for (int n = 0; n < 20; n++) begin
            int x;
            logic [31:0] r;
            x = 16 + int'($urandom % 200);
            arm1(x, 0, 32'h6);
            edges(x);
            rd(C1_CTL, d); check("R5 rnd before", d, ctl_exp(0, 1, 1));
            edges(1);
            rd(C1_CTL, d); check("R5 rnd match", d, ctl_exp(1, 1, 1));
            rd(C1_CNT, d); check("R3 rnd count", d, x + 1);
            r = $urandom;
            wr(C0_CMP, r); rd(C0_CMP, d); check("R2 rnd", d, r);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule